// File: doc/BRIEF.md
# Bit-Serial Time-of-Day Chip Slave

This block is the chip-side end of a three-wire serial link to a small clock and battery-RAM device. A processor runs the link by writing a control byte again and again. One bit of that byte is a session enable, one is a serial clock, and one is a bidirectional data bit. After each byte write the block returns the same byte, except that during a read transfer the data bit is replaced by the bit the device drives out. The surrounding register decoder stores the returned byte as the new control-register value.

A session is opened by raising the enable bit. The first eight falling clock edges shift in a command byte. The next eight edges either return a data byte or shift one in for storage, depending on the command. Dropping the enable bit closes the session.

The device holds 32 bytes of battery RAM, a status byte, a fixed control byte and six time-of-day fields. The time fields are supplied as BCD on input pins. One write command acknowledges status flags and pulses a request to clear an interrupt flag elsewhere in the system.

Top module: `tod_serial_slave`

## Requirements
- R1: In the written byte, bit 0 is enable, bit 1 is serial clock and bit 2 is serial data. Once a byte is written, `rd_byte` holds that byte with bits 7..3 and 1..0 unchanged; only bit 2 may differ. `rd_byte` is 0x00 after reset.
- R2: Writing a byte with enable low closes the session and clears the partial command and data. The next write with enable high starts again at the first command bit.
- R3: A bit is taken only on a falling edge, which is a write whose clock bit is 0 while enable is 1 and whose previous write had clock bit 1. Writes with no falling edge shift nothing and do not advance the transfer.
- R4: Falling edges 1 to 8 of a session shift the data bit into the command byte, most significant bit first.
- R5: For a command in 0x00..0x1F, falling edges 9 to 16 return RAM byte [command] on bit 2, most significant bit first.
- R6: Command 0x30 returns the status byte, which is 0x90 after reset. Command 0x31 returns the control byte, which is 0x00.
- R7: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return the seconds, minutes, hours, day, month and year input bytes. Every other command in 0x20..0x2F returns 0x00.
- R8: For a command in 0x80..0x9F, the bits sampled on falling edges 9 to 16 (most significant bit first) are written to RAM byte [command − 0x80] on the 16th edge.
- R9: Command 0xB1 completed with data bit 2 (value 0x04) set clears status bits 4 and 3. It also raises `irq_clr` for exactly one cycle, visible right after the 16th-edge write. With that bit clear, nothing changes.
- R10: After reset, RAM byte i holds ((i·29) mod 256) XOR 0xA5.
- R11: Falling edges after the 16th do nothing until the session is closed. Commands that are not readable (0x32..0x7F and 0x80 and above) return the data bit exactly as written.
- R12: `shift_log` shifts in each bit the block drives, newest in bit 0. It keeps its value across sessions and is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A control byte is written this cycle |
| wr_byte | input | 8 | Control byte being written |
| tod_sec | input | 8 | Seconds, BCD |
| tod_min | input | 8 | Minutes, BCD |
| tod_hour | input | 8 | Hours, BCD |
| tod_mday | input | 8 | Day of month, BCD |
| tod_month | input | 8 | Month 1..12, BCD |
| tod_year | input | 8 | Year within century, BCD |
| rd_byte | output | 8 | Updated control byte after the last write |
| shift_log | output | 8 | History of bits driven by the block |
| irq_clr | output | 1 | One-cycle request to clear the external interrupt flag |

## Verification
On the 16th falling edge, the shift of the last data bit and the store or flag-clear action happen on the same clock edge. The stored value must therefore include the bit arriving on that very write. The bench provokes this with RAM writes whose last bit differs from the preceding ones, and with an acknowledge word that has bit 2 set. It then judges the outcome by reading the RAM back and the status byte again, and by sampling `irq_clr` right after the 16th-edge write and once more one write later. Sessions aborted halfway and sessions run past 16 edges check that the same edge count cannot trigger a commit twice or out of place.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef logic [7:0] byte_t;

    localparam int BIT_EN  = 0;
    localparam int BIT_SCK = 1;
    localparam int BIT_DAT = 2;

    localparam int CMD_BITS  = 8;
    localparam int DATA_BITS = 8;

    localparam byte_t CMD_TOD_BASE   = 8'h20;
    localparam byte_t CMD_STATUS     = 8'h30;
    localparam byte_t CMD_CTRL       = 8'h31;
    localparam byte_t CMD_WR_BASE    = 8'h80;
    localparam byte_t CMD_FLAG_ACK   = 8'hB1;
    localparam int    ACK_BIT        = 2;
    localparam byte_t STATUS_CLR_MSK = 8'h18;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_RAM,
        SRC_TOD,
        SRC_STAT,
        SRC_CTRL
    } rd_src_e;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t mday;
        byte_t month;
        byte_t year;
    } tod_t;

    function automatic byte_t ram_default(input int unsigned idx);
        byte_t mul;
        mul = byte_t'((idx * 29) & 255);
        return mul ^ 8'hA5;
    endfunction

    function automatic rd_src_e classify(input byte_t cmd, input int unsigned words);
        if (int'(cmd) < int'(words))              return SRC_RAM;
        if (cmd[7:4] == CMD_TOD_BASE[7:4])        return SRC_TOD;
        if (cmd == CMD_STATUS)                    return SRC_STAT;
        if (cmd == CMD_CTRL)                      return SRC_CTRL;
        return SRC_NONE;
    endfunction

    function automatic byte_t tod_pick(input byte_t cmd, input tod_t t);
        case (cmd[3:0])
            4'h0:    return t.sec;
            4'h1:    return t.min;
            4'h2:    return t.hour;
            4'h4:    return t.mday;
            4'h5:    return t.month;
            4'h6:    return t.year;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/tsc_phase.sv
module tsc_phase
    import tsc_pkg::*;
#(
    parameter int PH_W   = 5,
    parameter int PH_CAP = CMD_BITS + DATA_BITS + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       en,
    input  logic       sck,
    output logic       cmd_step,
    output logic       dat_step,
    output logic       commit,
    output logic [2:0] bit_sel
);

    localparam int LAST_PH = CMD_BITS + DATA_BITS - 1;

    logic            idle_q;
    logic            sck_q;
    logic [PH_W-1:0] cnt_q;
    logic [PH_W-1:0] ph_cur;
    logic            fall;

    // Phase seen by this write: an idle link starts at 0 as soon as enable is high
    assign ph_cur   = idle_q ? '0 : cnt_q;
    assign fall     = wr_en & en & sck_q & ~sck;
    assign cmd_step = fall && (ph_cur < PH_W'(CMD_BITS));
    assign dat_step = fall && (ph_cur >= PH_W'(CMD_BITS)) && (ph_cur <= PH_W'(LAST_PH));
    assign commit   = fall && (ph_cur == PH_W'(LAST_PH));
    assign bit_sel  = 3'(DATA_BITS - 1) - ph_cur[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b1;
            sck_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (wr_en) begin
            sck_q <= sck;
            if (!en) begin
                idle_q <= 1'b1;
                cnt_q  <= '0;
            end else begin
                idle_q <= 1'b0;
                if (fall)
                    cnt_q <= (ph_cur >= PH_W'(PH_CAP)) ? PH_W'(PH_CAP) : ph_cur + 1'b1;
                else
                    cnt_q <= ph_cur;
            end
        end
    end

    AST_PHASE_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= PH_W'(PH_CAP));                                           // R11
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && en && !fall && !idle_q) |=> $stable(cnt_q));             // R3
    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !en) |=> (idle_q && cnt_q == '0));                       // R2

endmodule

// File: rtl/tsc_shift.sv
module tsc_shift
    import tsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  en,
    input  logic  din,
    input  logic  cmd_step,
    input  logic  dat_step,
    output byte_t cmd,
    output byte_t val_new
);

    byte_t      cmd_q;
    logic [6:0] val_q;

    assign cmd     = cmd_q;
    assign val_new = {val_q, din};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            val_q <= '0;
        end else if (wr_en) begin
            if (!en) begin
                cmd_q <= '0;
                val_q <= '0;
            end else begin
                if (cmd_step) cmd_q <= {cmd_q[6:0], din};
                if (dat_step) val_q <= val_new[6:0];
            end
        end
    end

    AST_CLEAR_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !en) |=> (cmd_q == 8'h00 && val_q == 7'h00));            // R2
    AST_CMD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cmd_step |=> $stable(cmd_q) || $past(wr_en && !en));               // R4

endmodule

// File: rtl/tsc_store.sv
module tsc_store
    import tsc_pkg::*;
#(
    parameter int    RAM_WORDS   = 32,
    parameter byte_t STATUS_INIT = 8'h90,
    parameter byte_t CTRL_VAL    = 8'h00
) (
    input  logic  clk,
    input  logic  rst,
    input  byte_t cmd,
    input  logic  commit,
    input  byte_t val_new,
    input  tod_t  tod,
    output byte_t src_byte,
    output logic  src_hit,
    output logic  irq_clr
);

    localparam int AW = $clog2(RAM_WORDS);

    byte_t                ram_q [RAM_WORDS];
    byte_t                status_q;
    logic                 irq_q;
    logic [RAM_WORDS-1:0] word_we;
    logic                 wr_ram;
    logic                 ack_flags;
    rd_src_e              src;

    assign wr_ram    = commit && (cmd >= CMD_WR_BASE)
                       && (int'(cmd) < int'(CMD_WR_BASE) + RAM_WORDS);
    assign ack_flags = commit && (cmd == CMD_FLAG_ACK) && val_new[ACK_BIT];

    for (genvar g = 0; g < RAM_WORDS; g++) begin : g_we
        assign word_we[g] = wr_ram && (cmd[AW-1:0] == AW'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < RAM_WORDS; i++) begin
            if (rst)             ram_q[i] <= ram_default(i);
            else if (word_we[i]) ram_q[i] <= val_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= STATUS_INIT;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= ack_flags;
            if (ack_flags) status_q <= status_q & ~STATUS_CLR_MSK;
        end
    end

    always_comb begin
        src = classify(cmd, RAM_WORDS);
        case (src)
            SRC_RAM:  src_byte = ram_q[cmd[AW-1:0]];
            SRC_TOD:  src_byte = tod_pick(cmd, tod);
            SRC_STAT: src_byte = status_q;
            SRC_CTRL: src_byte = CTRL_VAL;
            default:  src_byte = 8'h00;
        endcase
        src_hit = (src != SRC_NONE);
    end

    assign irq_clr = irq_q;

    AST_STATUS_NO_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q)) == 8'h00));                 // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (cmd == CMD_FLAG_ACK && (status_q & STATUS_CLR_MSK) == 8'h00)); // R9
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q || $past(ack_flags));                              // R9
    AST_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(word_we));                                                 // R8

endmodule

// File: rtl/tod_serial_slave.sv
module tod_serial_slave
    import tsc_pkg::*;
#(
    parameter int          RAM_WORDS   = 32,
    parameter logic [7:0]  STATUS_INIT = 8'h90,
    parameter logic [7:0]  CTRL_VAL    = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    input  logic [7:0] tod_sec,
    input  logic [7:0] tod_min,
    input  logic [7:0] tod_hour,
    input  logic [7:0] tod_mday,
    input  logic [7:0] tod_month,
    input  logic [7:0] tod_year,
    output logic [7:0] rd_byte,
    output logic [7:0] shift_log,
    output logic       irq_clr
);

    logic       cmd_step, dat_step, commit;
    logic [2:0] bit_sel;
    byte_t      cmd, val_new, src_byte;
    logic       src_hit;
    logic       drive, out_bit;
    byte_t      nxt_byte;
    byte_t      rd_q, log_q;
    tod_t       tod;

    assign tod = '{sec: tod_sec, min: tod_min, hour: tod_hour,
                   mday: tod_mday, month: tod_month, year: tod_year};

    tsc_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .en       (wr_byte[BIT_EN]),
        .sck      (wr_byte[BIT_SCK]),
        .cmd_step (cmd_step),
        .dat_step (dat_step),
        .commit   (commit),
        .bit_sel  (bit_sel)
    );

    tsc_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .en       (wr_byte[BIT_EN]),
        .din      (wr_byte[BIT_DAT]),
        .cmd_step (cmd_step),
        .dat_step (dat_step),
        .cmd      (cmd),
        .val_new  (val_new)
    );

    tsc_store #(
        .RAM_WORDS   (RAM_WORDS),
        .STATUS_INIT (STATUS_INIT),
        .CTRL_VAL    (CTRL_VAL)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .commit   (commit),
        .val_new  (val_new),
        .tod      (tod),
        .src_byte (src_byte),
        .src_hit  (src_hit),
        .irq_clr  (irq_clr)
    );

    assign drive   = dat_step && src_hit;
    assign out_bit = src_byte[bit_sel];

    always_comb begin
        nxt_byte          = wr_byte;
        nxt_byte[BIT_DAT] = drive ? out_bit : wr_byte[BIT_DAT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            log_q <= '0;
        end else if (wr_en) begin
            rd_q <= nxt_byte;
            if (drive) log_q <= {log_q[6:0], out_bit};
        end
    end

    assign rd_byte   = rd_q;
    assign shift_log = log_q;

    AST_BYTE_PASS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_q[7:3] == $past(wr_byte[7:3]) && rd_q[1:0] == $past(wr_byte[1:0]))); // R1
    AST_LOG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(log_q));                                          // R12
    AST_PASS_DATA: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dat_step) |=> rd_q[BIT_DAT] == $past(wr_byte[BIT_DAT]));  // R11

endmodule

// File: tb/tod_serial_slave_bench.sv
module tod_serial_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [7:0] t_sec = 8'h59, t_min = 8'h07, t_hour = 8'h23;
    logic [7:0] t_mday = 8'h31, t_mon = 8'h12, t_year = 8'h24;
    logic [7:0] rd_byte, shift_log;
    logic       irq_clr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_serial_slave u_tod_serial_slave (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .tod_sec   (t_sec),
        .tod_min   (t_min),
        .tod_hour  (t_hour),
        .tod_mday  (t_mday),
        .tod_month (t_mon),
        .tod_year  (t_year),
        .rd_byte   (rd_byte),
        .shift_log (shift_log),
        .irq_clr   (irq_clr)
    );

    function automatic logic [7:0] exp_ram(input int i);
        return 8'(((i * 29) & 255) ^ 8'hA5);
    endfunction

    function automatic logic [7:0] exp_tod(input logic [7:0] c);
        case (c)
            8'h20: return t_sec;
            8'h21: return t_min;
            8'h22: return t_hour;
            8'h24: return t_mday;
            8'h25: return t_mon;
            8'h26: return t_year;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, output logic [7:0] r);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_byte = b;
        @(negedge clk);
        wr_en   = 1'b0;
        r       = rd_byte;
    endtask

    task automatic edge_bit(input bit d, output bit rb);
        logic [7:0] r;
        put(8'h03 | {5'b0, d, 2'b00}, r);
        put(8'h01 | {5'b0, d, 2'b00}, r);
        rb = r[2];
    endtask

    task automatic session(input logic [7:0] c, input logic [7:0] wv,
                           output logic [7:0] rv, output bit irq_seen);
        logic [7:0] r;
        bit b;
        put(8'h01, r);
        for (int i = 7; i >= 0; i--) edge_bit(c[i], b);
        for (int i = 7; i >= 0; i--) begin
            edge_bit(wv[i], b);
            rv[i] = b;
        end
        irq_seen = irq_clr;
        put(8'h00, r);
    endtask

    task automatic rd(input logic [7:0] c, output logic [7:0] rv);
        bit s;
        session(c, 8'h00, rv, s);
    endtask

    initial begin
        logic [7:0] rv, r;
        bit irq, b;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_byte == 8'h00, "R1 reset rd_byte", rd_byte, 8'h00);
        check(shift_log == 8'h00, "R12 reset shift_log", shift_log, 8'h00);
        check(irq_clr == 1'b0, "R9 reset irq_clr", irq_clr, 0);

        // R1: non-data bits returned as written
        put(8'hF0, r);
        check(r == 8'hF0, "R1 byte pass F0", r, 8'hF0);
        put(8'h6C, r);
        check(r == 8'h6C, "R1 byte pass 6C", r, 8'h6C);
        put(8'h00, r);

        // R3: extra low writes with flipped data add no edge; status read
        put(8'h01, r);
        for (int i = 7; i >= 0; i--) begin
            bit d;
            d = CMD_ST[i];
            edge_bit(d, b);
            put(8'h01 | {5'b0, ~d, 2'b00}, r);
        end
        for (int i = 7; i >= 0; i--) begin
            edge_bit(1'b0, b);
            rv[i] = b;
            put(8'h05, r);
        end
        put(8'h00, r);
        check(rv == 8'h90, "R3 R6 status via repeated-low writes", rv, 8'h90);
        check(shift_log == 8'h90, "R12 log after status read", shift_log, 8'h90);

        // R4 R5 R10: whole RAM default sweep
        for (int i = 0; i < 32; i++) begin
            rd(8'(i), rv);
            check(rv == exp_ram(i), $sformatf("R4 R5 R10 ram[%0d]", i), rv, exp_ram(i));
        end
        check(shift_log == exp_ram(31), "R12 log after ram read", shift_log, exp_ram(31));

        // R6 control
        rd(8'h31, rv);
        check(rv == 8'h00, "R6 control", rv, 8'h00);

        // R7 time sweep
        for (int c = 8'h20; c <= 8'h2F; c++) begin
            rd(8'(c), rv);
            check(rv == exp_tod(8'(c)), $sformatf("R7 tod cmd %0h", c), rv, exp_tod(8'(c)));
        end

        // R2: abort mid-command then clean read
        put(8'h01, r);
        for (int i = 0; i < 4; i++) edge_bit(1'b1, b);
        put(8'h00, r);
        rd(8'h05, rv);
        check(rv == exp_ram(5), "R2 read after abort", rv, exp_ram(5));

        // R8 writes, last bit differs from others
        session(8'h80, 8'hC3, rv, irq);
        session(8'h91, 8'hFE, rv, irq);
        session(8'h9F, 8'h01, rv, irq);
        check(irq == 1'b0, "R9 no irq on ram write", irq, 0);
        rd(8'h00, rv); check(rv == 8'hC3, "R8 ram[0]", rv, 8'hC3);
        rd(8'h11, rv); check(rv == 8'hFE, "R8 ram[17]", rv, 8'hFE);
        rd(8'h1F, rv); check(rv == 8'h01, "R8 ram[31]", rv, 8'h01);
        rd(8'h01, rv); check(rv == exp_ram(1), "R8 ram[1] untouched", rv, exp_ram(1));

        // R11: non-readable command passes data; log untouched
        r = shift_log;
        session(8'h40, 8'h5A, rv, irq);
        check(rv == 8'h5A, "R11 passthrough cmd 40", rv, 8'h5A);
        check(shift_log == r, "R12 log hold on non-read", shift_log, r);

        // R11: edges past 16 do nothing
        put(8'h01, r);
        for (int i = 7; i >= 0; i--) edge_bit(CMD_W3[i], b);
        for (int i = 7; i >= 0; i--) edge_bit(VAL_3C[i], b);
        for (int i = 0; i < 8; i++) begin
            edge_bit(1'b1, b);
            check(b == 1'b1, "R11 extra edge returns written bit", b, 1);
        end
        put(8'h00, r);
        rd(8'h03, rv);
        check(rv == 8'h3C, "R11 ram[3] after extra edges", rv, 8'h3C);

        // R9 acknowledge
        session(8'hB1, 8'hFB, rv, irq);
        check(irq == 1'b0, "R9 no irq without bit2", irq, 0);
        rd(8'h30, rv);
        check(rv == 8'h90, "R9 status kept without bit2", rv, 8'h90);
        session(8'hB1, 8'h04, rv, irq);
        check(irq == 1'b1, "R9 irq pulse on ack", irq, 1);
        check(irq_clr == 1'b0, "R9 irq one cycle", irq_clr, 0);
        rd(8'h30, rv);
        check(rv == 8'h80, "R9 status flags cleared", rv, 8'h80);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    localparam logic [7:0] CMD_ST = 8'h30;
    localparam logic [7:0] CMD_W3 = 8'h83;
    localparam logic [7:0] VAL_3C = 8'h3C;

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule